// File: doc/BRIEF.md
# Vertex Output Varying Packer

The packer takes the outputs of one vertex as a stream of tagged values and places each one at its word in a fixed output array. Every value arrives with a class code, an index inside its class, 32 bits of data and a pair flag. The array starts with the four position words. The 32-bit varyings follow, then the 16-bit varyings two to a word, then the point size, then the clip distances. Each accepted value gives one registered write of a word index, word data and a two-bit lane enable (bit 0 for the low half, bit 1 for the high half). A storage array beside the block merges these writes, so 16-bit halves can arrive in any order.

The sizes of the groups come from configuration inputs. The block sums them to find the first word of each group. It takes those sums at the first value it accepts for a vertex and holds them until the vertex is complete. A header output gives the number of 32-bit varying slots, so a consumer can tell a full-width slot from a 16-bit pair slot. When every configured value has been accepted, a done pulse marks the end of the vertex. A value that does not fit the configuration raises an error pulse and is dropped.

Top module: `vout_packer`

## Requirements
- R1: Class code 0 (position) with index 0 to 3 writes word 0 to 3, with the data unchanged and lane enable 2'b11. The write appears one cycle after the value is accepted.
- R2: Class codes 1 (smooth), 2 (flat) and 3 (linear) are the 32-bit varyings. They follow the position in that group order, so each group starts right after the previous one's configured count. Index i of a group writes word base+i with lane enable 2'b11.
- R3: Class codes 4 (smooth), 5 (flat) and 6 (linear) are 16-bit varyings. They follow the 32-bit varyings in that group order, and each group takes ceil(count/2) words. Index i writes word base+i/2. An even index puts data[15:0] in the low half with lanes 2'b01. An odd index puts data[15:0] in the high half, the low half zero, with lanes 2'b10.
- R4: When a 16-bit group has an odd count, the write for its last value has lane enable 2'b11 and a zero high half.
- R5: A 16-bit class with in_pair set, an even index i and i+1 below the count writes both values at once: data[15:0] is value i and data[31:16] is value i+1, with lanes 2'b11. The pair counts as two values. The pair flag on any other class, on an odd index, or with i+1 at or above the count is an error.
- R6: Class code 7 (point size, index 0, only when enabled) takes the word after the 16-bit region. Class code 8 (clip distance) follows it, one word per plane. A configured clip count above 16 is treated as 16.
- R7: hdr_n32 equals the sum of the three 32-bit group counts of the current vertex. For any varying word w, slot w-4 is below hdr_n32 exactly when it holds a 32-bit varying.
- R8: The group counts are captured at the first accepted value of a vertex. Changing the configuration inputs while the vertex is in progress does not change its word indices, its completion point or its header.
- R9: done pulses for one cycle, in the same cycle as the write of the value that completes the configured total. The next accepted value starts a new vertex.
- R10: An accepted value with class code 9 to 15, an index at or above its group's count, or an illegal pair flag pulses err for one cycle. It makes no write, does not advance completion and does not raise done.
- R11: During and right after reset, wr_valid, done and err are low and hdr_n32 is zero. in_ready is high once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_s32 | input | CW | Count of 32-bit smooth varyings |
| cfg_f32 | input | CW | Count of 32-bit flat varyings |
| cfg_l32 | input | CW | Count of 32-bit linear varyings |
| cfg_s16 | input | CW | Count of 16-bit smooth varyings |
| cfg_f16 | input | CW | Count of 16-bit flat varyings |
| cfg_l16 | input | CW | Count of 16-bit linear varyings |
| cfg_psize | input | 1 | Point size word present |
| cfg_nclip | input | NW | Number of clip planes (clamped to NCLIP) |
| in_valid | input | 1 | Input value valid |
| in_ready | output | 1 | Input may be accepted |
| in_kind | input | 4 | Class code of the value |
| in_index | input | XW | Index inside its class |
| in_pair | input | 1 | Data carries two aligned 16-bit values |
| in_data | input | 32 | Value data |
| wr_valid | output | 1 | Word write valid |
| wr_idx | output | IW | Word index of the write |
| wr_data | output | 32 | Word data |
| wr_lanes | output | 2 | Half enables: bit 0 low half, bit 1 high half |
| hdr_n32 | output | IW | Number of 32-bit varying slots |
| done | output | 1 | Vertex complete pulse |
| err | output | 1 | Dropped-input pulse |

## Verification
The bench goes after 16-bit groups with odd counts. A design that missed that case would leave the top half of the last word unwritten, or would put it at the next group's first word. It sends aligned pairs next to misaligned and overhanging ones. A wrong pair check would either drop legal pairs or write a half that belongs to the next group. It changes the configuration in the middle of a vertex, and a design that read live counts would move later words and end the vertex early or late. It also drives a clip count above the limit and invalid class codes. A wrong clamp or error path would either write past the array or count a dropped value toward done.

// File: rtl/vout_packer.sv
module vout_packer #(
  parameter int CW    = 4,
  parameter int NCLIP = 16,
  localparam int NW   = $clog2(NCLIP + 1),
  localparam int XW   = (CW > NW) ? CW : NW,
  localparam int MAXC = (1 << CW) - 1,
  localparam int MAXW = 4 + 3 * MAXC + 3 * ((MAXC + 1) / 2) + 1 + NCLIP,
  localparam int IW   = $clog2(MAXW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_s32,
  input  logic [CW-1:0] cfg_f32,
  input  logic [CW-1:0] cfg_l32,
  input  logic [CW-1:0] cfg_s16,
  input  logic [CW-1:0] cfg_f16,
  input  logic [CW-1:0] cfg_l16,
  input  logic          cfg_psize,
  input  logic [NW-1:0] cfg_nclip,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    in_kind,
  input  logic [XW-1:0] in_index,
  input  logic          in_pair,
  input  logic [31:0]   in_data,
  output logic          wr_valid,
  output logic [IW-1:0] wr_idx,
  output logic [31:0]   wr_data,
  output logic [1:0]    wr_lanes,
  output logic [IW-1:0] hdr_n32,
  output logic          done,
  output logic          err
);
  localparam int MAXV = 4 + 6 * MAXC + 1 + NCLIP;
  localparam int VW   = $clog2(MAXV + 1);

  localparam logic [3:0] K_POS = 4'd0, K_S32 = 4'd1, K_F32 = 4'd2, K_L32 = 4'd3;
  localparam logic [3:0] K_S16 = 4'd4, K_F16 = 4'd5, K_L16 = 4'd6;
  localparam logic [3:0] K_PSZ = 4'd7, K_CLP = 4'd8;

  logic [CW-1:0] q_s32, q_f32, q_l32, q_s16, q_f16, q_l16;
  logic          q_ps;
  logic [NW-1:0] q_ncl;
  logic [VW-1:0] cnt;

  logic          idle;
  logic [CW-1:0] e_s32, e_f32, e_l32, e_s16, e_f16, e_l16;
  logic          e_ps;
  logic [NW-1:0] ncl_in, e_ncl;

  function automatic logic [IW-1:0] words16(input logic [CW-1:0] n);
    return (IW'(n) + IW'(1)) >> 1;
  endfunction

  assign in_ready = rst_n;
  assign idle     = (cnt == '0);
  assign ncl_in   = (cfg_nclip > NW'(NCLIP)) ? NW'(NCLIP) : cfg_nclip;

  assign e_s32 = idle ? cfg_s32   : q_s32;
  assign e_f32 = idle ? cfg_f32   : q_f32;
  assign e_l32 = idle ? cfg_l32   : q_l32;
  assign e_s16 = idle ? cfg_s16   : q_s16;
  assign e_f16 = idle ? cfg_f16   : q_f16;
  assign e_l16 = idle ? cfg_l16   : q_l16;
  assign e_ps  = idle ? cfg_psize : q_ps;
  assign e_ncl = idle ? ncl_in    : q_ncl;

  logic [IW-1:0] b_f32, b_l32, b_s16, b_f16, b_l16, b_ps, b_cl;
  logic [VW-1:0] tot;

  assign b_f32 = IW'(4) + IW'(e_s32);
  assign b_l32 = b_f32 + IW'(e_f32);
  assign b_s16 = b_l32 + IW'(e_l32);
  assign b_f16 = b_s16 + words16(e_s16);
  assign b_l16 = b_f16 + words16(e_f16);
  assign b_ps  = b_l16 + words16(e_l16);
  assign b_cl  = b_ps + IW'(e_ps);

  assign tot = VW'(4) + VW'(e_s32) + VW'(e_f32) + VW'(e_l32)
             + VW'(e_s16) + VW'(e_f16) + VW'(e_l16)
             + VW'(e_ps) + VW'(e_ncl);

  assign hdr_n32 = IW'(q_s32) + IW'(q_f32) + IW'(q_l32);

  logic [IW-1:0] g_cnt, g_base, ix, ix1, n_idx;
  logic          is16, bad_kind, bad, last_odd;
  logic [31:0]   n_data;
  logic [1:0]    n_lanes;
  logic [VW-1:0] nxt;

  always_comb begin
    g_cnt    = '0;
    g_base   = '0;
    is16     = 1'b0;
    bad_kind = 1'b0;
    case (in_kind)
      K_POS: begin g_cnt = IW'(4);       g_base = '0;     end
      K_S32: begin g_cnt = IW'(e_s32);   g_base = IW'(4); end
      K_F32: begin g_cnt = IW'(e_f32);   g_base = b_f32;  end
      K_L32: begin g_cnt = IW'(e_l32);   g_base = b_l32;  end
      K_S16: begin g_cnt = IW'(e_s16);   g_base = b_s16;  is16 = 1'b1; end
      K_F16: begin g_cnt = IW'(e_f16);   g_base = b_f16;  is16 = 1'b1; end
      K_L16: begin g_cnt = IW'(e_l16);   g_base = b_l16;  is16 = 1'b1; end
      K_PSZ: begin g_cnt = IW'(e_ps);    g_base = b_ps;   end
      K_CLP: begin g_cnt = IW'(e_ncl);   g_base = b_cl;   end
      default: bad_kind = 1'b1;
    endcase
  end

  assign ix       = IW'(in_index);
  assign ix1      = ix + IW'(1);
  assign bad      = bad_kind || (ix >= g_cnt) ||
                    (in_pair && (!is16 || ix[0] || (ix1 >= g_cnt)));
  assign n_idx    = is16 ? g_base + (ix >> 1) : g_base + ix;
  assign last_odd = g_cnt[0] && (ix1 == g_cnt);
  assign nxt      = cnt + (in_pair ? VW'(2) : VW'(1));

  always_comb begin
    if (!is16 || in_pair) begin
      n_data  = in_data;
      n_lanes = 2'b11;
    end else if (!ix[0]) begin
      n_data  = {16'h0000, in_data[15:0]};
      n_lanes = last_odd ? 2'b11 : 2'b01;
    end else begin
      n_data  = {in_data[15:0], 16'h0000};
      n_lanes = 2'b10;
    end
  end

  logic acc;
  assign acc = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      wr_valid <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
      wr_lanes <= 2'b00;
      done     <= 1'b0;
      err      <= 1'b0;
      q_s32 <= '0; q_f32 <= '0; q_l32 <= '0;
      q_s16 <= '0; q_f16 <= '0; q_l16 <= '0;
      q_ps  <= 1'b0;
      q_ncl <= '0;
    end else begin
      wr_valid <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      if (acc && bad) begin
        err <= 1'b1;
      end else if (acc) begin
        wr_valid <= 1'b1;
        wr_idx   <= n_idx;
        wr_data  <= n_data;
        wr_lanes <= n_lanes;
        if (idle) begin
          q_s32 <= e_s32; q_f32 <= e_f32; q_l32 <= e_l32;
          q_s16 <= e_s16; q_f16 <= e_f16; q_l16 <= e_l16;
          q_ps  <= e_ps;
          q_ncl <= e_ncl;
        end
        if (nxt >= tot) begin
          cnt  <= '0;
          done <= 1'b1;
        end else begin
          cnt <= nxt;
        end
      end
    end
  end

  // R10
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!wr_valid && !done));

  // R9
  done_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> wr_valid);

  // R3
  lanes_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_lanes != 2'b00));

  // R7
  half_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_lanes != 2'b11) |-> (wr_idx >= IW'(4) + hdr_n32));

  // R8
  hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(hdr_n32));

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> (cnt < tot));
endmodule

// File: tb/vout_packer_bench.sv
module vout_packer_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] cfg_s32, cfg_f32, cfg_l32, cfg_s16, cfg_f16, cfg_l16;
  logic       cfg_psize;
  logic [4:0] cfg_nclip;
  logic       in_valid, in_ready, in_pair;
  logic [3:0] in_kind;
  logic [4:0] in_index;
  logic [31:0] in_data;
  logic       wr_valid, done, err;
  logic [6:0] wr_idx, hdr_n32;
  logic [31:0] wr_data;
  logic [1:0] wr_lanes;

  vout_packer u_vout_packer (
    .clk(clk), .rst_n(rst_n),
    .cfg_s32(cfg_s32), .cfg_f32(cfg_f32), .cfg_l32(cfg_l32),
    .cfg_s16(cfg_s16), .cfg_f16(cfg_f16), .cfg_l16(cfg_l16),
    .cfg_psize(cfg_psize), .cfg_nclip(cfg_nclip),
    .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
    .in_index(in_index), .in_pair(in_pair), .in_data(in_data),
    .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data),
    .wr_lanes(wr_lanes), .hdr_n32(hdr_n32), .done(done), .err(err)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int s_cnt[9];
  int total, accepted;
  int it_k[128], it_i[128], it_p[128];
  int n_items;
  int c_s32, c_f32, c_l32, c_s16, c_f16, c_l16, c_ps, c_ncl;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int gcnt(input int k);
    if (k >= 0 && k <= 8) return s_cnt[k];
    return -1;
  endfunction

  function automatic int gbase(input int k);
    int b = 0;
    for (int g = 0; g < k; g++) begin
      if (g >= 4 && g <= 6) b += (s_cnt[g] + 1) / 2;
      else b += s_cnt[g];
    end
    return b;
  endfunction

  task automatic apply_cfg();
    cfg_s32 = 4'(c_s32); cfg_f32 = 4'(c_f32); cfg_l32 = 4'(c_l32);
    cfg_s16 = 4'(c_s16); cfg_f16 = 4'(c_f16); cfg_l16 = 4'(c_l16);
    cfg_psize = c_ps[0]; cfg_nclip = 5'(c_ncl);
    s_cnt[0] = 4; s_cnt[1] = c_s32; s_cnt[2] = c_f32; s_cnt[3] = c_l32;
    s_cnt[4] = c_s16; s_cnt[5] = c_f16; s_cnt[6] = c_l16;
    s_cnt[7] = c_ps; s_cnt[8] = (c_ncl > 16) ? 16 : c_ncl;
    total = 0;
    for (int g = 0; g < 9; g++) total += s_cnt[g];
    accepted = 0;
  endtask

  task automatic send(input int k, input int ix, input bit pr, input logic [31:0] d);
    int c, e_idx, e_ln;
    bit good, is16;
    logic [31:0] e_dat;
    string tg;
    c = gcnt(k);
    is16 = (k >= 4 && k <= 6);
    good = (c >= 0) && (ix < c) && (!pr || (is16 && ix % 2 == 0 && ix + 1 < c));
    e_idx = 0; e_dat = '0; e_ln = 3;
    if (good) begin
      if (!is16 || pr) begin
        e_idx = gbase(k) + (is16 ? ix / 2 : ix);
        e_dat = d;
      end else if (ix % 2 == 0) begin
        e_idx = gbase(k) + ix / 2;
        e_dat = {16'h0000, d[15:0]};
        e_ln  = (c % 2 == 1 && ix == c - 1) ? 3 : 1;
      end else begin
        e_idx = gbase(k) + ix / 2;
        e_dat = {d[15:0], 16'h0000};
        e_ln  = 2;
      end
    end
    if (k == 0) tg = "R1 position";
    else if (k <= 3) tg = "R2 32-bit varying";
    else if (k <= 6) tg = pr ? "R5 pair" : ((e_ln == 3) ? "R4 odd tail" : "R3 half");
    else tg = "R6 psize/clip";
    in_valid = 1'b1; in_kind = 4'(k); in_index = 5'(ix); in_pair = pr; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    if (!good) begin
      chk("R10 err pulse", err, 1);
      chk("R10 no write", wr_valid, 0);
      chk("R10 no done", done, 0);
      return;
    end
    accepted += pr ? 2 : 1;
    chk({tg, " valid"}, wr_valid, 1);
    chk({tg, " idx (R8 latched)"}, wr_idx, e_idx);
    chk({tg, " data"}, wr_data, e_dat);
    chk({tg, " lanes"}, wr_lanes, e_ln);
    chk("R10 no err on good", err, 0);
    chk("R9 done timing", done, accepted == total);
    if (k >= 1 && k <= 6)
      chk("R7 slot class", (int'(wr_idx) - 4) < int'(hdr_n32), k <= 3);
    if (accepted == total) accepted = 0;
  endtask

  task automatic send_bad();
    int t, k;
    t = int'($urandom % 4);
    case (t)
      0: send(9 + int'($urandom % 7), 0, 1'b0, $urandom);
      1: begin
        k = int'($urandom % 9);
        send(k, gcnt(k) + int'($urandom % (32 - gcnt(k))), 1'b0, $urandom);
      end
      2: send(4 + int'($urandom % 3), 2 * int'($urandom % 8) + 1, 1'b1, $urandom);
      default: send(int'($urandom % 4), 0, 1'b1, $urandom);
    endcase
  endtask

  task automatic build_items();
    int t0, t1, t2;
    n_items = 0;
    for (int k = 0; k < 9; k++) begin
      int i = 0;
      while (i < s_cnt[k]) begin
        if (k >= 4 && k <= 6 && i % 2 == 0 && i + 1 < s_cnt[k] && $urandom % 2 == 1) begin
          it_k[n_items] = k; it_i[n_items] = i; it_p[n_items] = 1; i += 2;
        end else begin
          it_k[n_items] = k; it_i[n_items] = i; it_p[n_items] = 0; i += 1;
        end
        n_items++;
      end
    end
    for (int i = n_items - 1; i > 0; i--) begin
      int j = int'($urandom % (i + 1));
      t0 = it_k[i]; t1 = it_i[i]; t2 = it_p[i];
      it_k[i] = it_k[j]; it_i[i] = it_i[j]; it_p[i] = it_p[j];
      it_k[j] = t0; it_i[j] = t1; it_p[j] = t2;
    end
  endtask

  task automatic run_vertex(input bit midchg, input bit inject);
    build_items();
    for (int i = 0; i < n_items; i++) begin
      if (inject && $urandom % 6 == 0) send_bad();
      send(it_k[i], it_i[i], it_p[i][0], $urandom);
      if (i == 0) begin
        chk("R7 header count", hdr_n32, s_cnt[1] + s_cnt[2] + s_cnt[3]);
        if (midchg) begin
          cfg_s32 = 4'($urandom); cfg_f32 = 4'($urandom); cfg_l32 = 4'($urandom);
          cfg_s16 = 4'($urandom); cfg_f16 = 4'($urandom); cfg_l16 = 4'($urandom);
          cfg_psize = 1'($urandom); cfg_nclip = 5'($urandom);
        end
      end
    end
    @(negedge clk);
    chk("R9 done one cycle", done, 0);
    chk("R9 no stray write", wr_valid, 0);
    if (midchg) chk("R8 header held", hdr_n32, s_cnt[1] + s_cnt[2] + s_cnt[3]);
  endtask

  task automatic rand_cfg();
    c_s32 = int'($urandom % 16); c_f32 = int'($urandom % 16); c_l32 = int'($urandom % 16);
    c_s16 = int'($urandom % 16); c_f16 = int'($urandom % 16); c_l16 = int'($urandom % 16);
    c_ps = int'($urandom % 2); c_ncl = int'($urandom % 24);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; in_kind = '0; in_index = '0; in_pair = 1'b0; in_data = '0;
    c_s32 = 0; c_f32 = 0; c_l32 = 0; c_s16 = 0; c_f16 = 0; c_l16 = 0; c_ps = 0; c_ncl = 0;
    apply_cfg();
    repeat (3) @(negedge clk);
    chk("R11 reset wr_valid", wr_valid, 0);
    chk("R11 reset done", done, 0);
    chk("R11 reset err", err, 0);
    chk("R11 reset hdr", hdr_n32, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 ready after reset", in_ready, 1);

    apply_cfg();
    run_vertex(1'b0, 1'b0);

    c_s32 = 2; c_f32 = 1; c_l32 = 0; c_s16 = 3; c_f16 = 1; c_l16 = 5; c_ps = 1; c_ncl = 3;
    apply_cfg();
    send(5, 0, 1'b1, 32'hDEAD_BEEF);
    accepted = 0;
    run_vertex(1'b0, 1'b0);

    c_s32 = 1; c_f32 = 0; c_l32 = 1; c_s16 = 2; c_f16 = 0; c_l16 = 0; c_ps = 1; c_ncl = 20;
    apply_cfg();
    send(8, 16, 1'b0, 32'h1234_5678);
    send(8, 15, 1'b0, 32'h0BAD_F00D);
    send(4, 0, 1'b1, 32'hAAAA_5555);
    build_items();
    for (int i = 0; i < n_items; i++) begin
      if (!(it_k[i] == 8 && it_i[i] == 15) && !(it_k[i] == 4))
        send(it_k[i], it_i[i], it_p[i][0], $urandom);
    end
    @(negedge clk);
    chk("R9 clamped vertex done clear", done, 0);

    c_s32 = 15; c_f32 = 15; c_l32 = 15; c_s16 = 15; c_f16 = 15; c_l16 = 15; c_ps = 1; c_ncl = 16;
    apply_cfg();
    run_vertex(1'b1, 1'b1);

    for (int v = 0; v < 40; v++) begin
      rand_cfg();
      apply_cfg();
      run_vertex(v % 2 == 0, 1'b1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule